// File: doc/BRIEF.md
# Bus-Width Assembly Sequencer with Re-drive

This block plans and paces the sub-cycles that a bridge runs on an expansion bus when the current master and slave have different data widths and the bridge is neither of them. When the master is wider than the slave, one wide transfer is split into narrower sub-cycles. This is disassembly. When the master is narrower than the slave, narrow pieces are gathered into one wide word. This is assembly. For each sub-cycle the block gives the byte lanes that take part. It also flags whether the bridge re-drives captured data onto the bus in that sub-cycle or lets the bus pass data through.

A transfer is launched with a start strobe, which carries the master width code, the slave width code and the byte enables. Each sub-cycle lasts until the ready input is sampled high. A capture register keeps the bytes gathered so far, so that the complete word is available for re-drive. A one-clock done pulse closes the sequence. The same sequencing serves both read and write transfers, because the direction of data does not change the lane order or the re-drive tagging.

Top module: `bwa_seq`

## Requirements
- R1: After reset, `cyc_active`, `redrive` and `done` are low, `lane_en` is zero and `bus_dout` is zero.
- R2: Width codes are 0 = 8 bits, 1 = 16 bits, and 2 or 3 = 32 bits. Sub-cycles use naturally aligned chunks of the narrower of the two widths. A chunk runs only if it contains an enabled byte. Chunks run from the lowest lane to the highest, and `lane_en` equals `be` (bit n = byte lane n, active high) masked to the current chunk.
- R3: A sub-cycle keeps its `lane_en` and stays active until `rdy` is sampled high. The next sub-cycle starts in the clock after that.
- R4: In disassembly (master code greater than slave code, two or more chunks), the first sub-cycle has `redrive` low and every later sub-cycle has it high.
- R5: In assembly (master code less than slave code, two or more chunks), only the final sub-cycle has `redrive` high.
- R6: When the clamped width codes are equal, or only one chunk is needed, every sub-cycle is pass-through with `redrive` low.
- R7: `done` is high for exactly one clock, in the clock after the final `rdy`. A start with `be` = 0 runs no sub-cycle and gives `done` in the clock after start.
- R8: A start strobe that arrives while a sequence is active is ignored. The running sequence continues unchanged.
- R9: The capture register is cleared when a start is accepted. In disassembly it captures every enabled byte of `bus_din` when the first sub-cycle completes. In assembly it captures the lanes of each sub-cycle when that sub-cycle completes. In pass-through it captures nothing. `bus_dout` always shows the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a transfer when idle |
| mst_wcode | input | 2 | Master width code |
| slv_wcode | input | 2 | Slave width code |
| be | input | 4 | Byte enables of the transfer, active high |
| rdy | input | 1 | Current sub-cycle completes when high |
| bus_din | input | 32 | Data seen on the bus |
| cyc_active | output | 1 | A sub-cycle is in progress |
| lane_en | output | 4 | Byte lanes of the current sub-cycle |
| redrive | output | 1 | Current sub-cycle is a re-drive cycle |
| done | output | 1 | One-clock end-of-sequence pulse |
| bus_dout | output | 32 | Captured data for re-drive |

## Verification
The sequencer is run with full enables through byte and word slaves, where every chunk is used. It is also run with sparse enables such as 0110 and 1101, which show whether empty chunks are skipped and whether lanes are masked inside a chunk. The same widths are applied in both directions, so that the disassembly tag pattern (all but the first) can be told apart from the assembly one (last only). Equal widths, a single-chunk mismatch, width code 3 and zero enables cover the pass-through and degenerate paths. A delayed ready on the first sub-cycle, together with a stray start in that window, shows that the hold logic and the busy guard work.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_ASM  = 2'd1,
    MODE_DIS  = 2'd2
  } mode_e;

  // Limit a width code to the widest code the lane count supports.
  function automatic int clamp_code(int code, int max_code);
    return (code > max_code) ? max_code : code;
  endfunction

  // Number of byte lanes covered by a width code.
  function automatic int lanes_of(int code);
    return 1 << code;
  endfunction

  // True when a lane belongs to a given aligned chunk of the given span.
  function automatic bit lane_in_chunk(int lane, int chunk, int span);
    return (lane / span) == chunk;
  endfunction

  // Conversion type from the clamped codes and the number of chunks in use.
  function automatic mode_e pick_mode(int mcode, int scode, int n_chunks);
    if (mcode == scode || n_chunks < 2) return MODE_PASS;
    else if (mcode > scode)             return MODE_DIS;
    else                                return MODE_ASM;
  endfunction

endpackage

// File: rtl/bwa_chunk_plan.sv
module bwa_chunk_plan #(
  parameter int LANES = 4,
  parameter int WCW   = 2,
  parameter int IDXW  = 2,
  parameter int CNTW  = 3
) (
  input  logic [LANES-1:0] be,
  input  logic [WCW-1:0]   span_code,
  input  logic [IDXW-1:0]  cur,
  output logic [LANES-1:0] cur_mask,
  output logic [IDXW-1:0]  first_idx,
  output logic [IDXW-1:0]  next_idx,
  output logic             has_next,
  output logic [CNTW-1:0]  n_present
);
  import bwa_pkg::*;

  logic [LANES-1:0] chunk_mask [LANES];
  logic [LANES-1:0] present;

  for (genvar k = 0; k < LANES; k++) begin : g_chunk
    always_comb begin
      for (int l = 0; l < LANES; l++)
        chunk_mask[k][l] = lane_in_chunk(l, k, lanes_of(int'(span_code)));
      present[k] = |(be & chunk_mask[k]);
    end
  end

  always_comb begin
    logic found;
    first_idx = '0;
    found     = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (present[k] && !found) begin
        first_idx = IDXW'(k);
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    next_idx = '0;
    found    = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (present[k] && (k > int'(cur)) && !found) begin
        next_idx = IDXW'(k);
        found    = 1'b1;
      end
    end
    has_next = found;
  end

  assign cur_mask  = chunk_mask[cur];
  assign n_present = CNTW'($countones(present));

endmodule

// File: rtl/bwa_capture.sv
module bwa_capture #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    cap_en,
  input  logic [LANES-1:0]        lanes,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dout[l*LANE_W +: LANE_W] <= '0;
      else if (clear)
        dout[l*LANE_W +: LANE_W] <= '0;
      else if (cap_en && lanes[l])
        dout[l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/bwa_seq.sv
module bwa_seq #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int MAXC  = $clog2(LANES),
  localparam int WCW   = (MAXC < 1) ? 1 : $clog2(MAXC + 1),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WCW-1:0]   mst_wcode,
  input  logic [WCW-1:0]   slv_wcode,
  input  logic [LANES-1:0] be,
  input  logic             rdy,
  input  logic [DW-1:0]    bus_din,
  output logic             cyc_active,
  output logic [LANES-1:0] lane_en,
  output logic             redrive,
  output logic             done,
  output logic [DW-1:0]    bus_dout
);
  import bwa_pkg::*;

  localparam int IDXW = (MAXC < 1) ? 1 : MAXC;
  localparam int CNTW = $clog2(LANES + 1);

  logic             busy;
  logic [IDXW-1:0]  cur_idx;
  logic [LANES-1:0] be_q;
  logic [WCW-1:0]   span_q;
  mode_e            mode_q;
  logic             first_q;
  logic             done_q;

  logic             start_acc;
  logic             zero_go;
  logic             step;
  logic             last_w;
  logic [WCW-1:0]   m_clamp, s_clamp, span_new;
  mode_e            mode_new;

  logic [LANES-1:0] plan_be;
  logic [WCW-1:0]   plan_span;
  logic [LANES-1:0] cur_mask;
  logic [IDXW-1:0]  first_idx, next_idx;
  logic             has_next;
  logic [CNTW-1:0]  n_present;

  logic             cap_en;
  logic [LANES-1:0] cap_lanes;

  // width decode at the edge of a new transfer
  always_comb begin
    m_clamp  = WCW'(clamp_code(int'(mst_wcode), MAXC));
    s_clamp  = WCW'(clamp_code(int'(slv_wcode), MAXC));
    span_new = (m_clamp < s_clamp) ? m_clamp : s_clamp;
    mode_new = pick_mode(int'(m_clamp), int'(s_clamp), int'(n_present));
  end

  assign plan_be   = busy ? be_q   : be;
  assign plan_span = busy ? span_q : span_new;

  bwa_chunk_plan #(
    .LANES(LANES), .WCW(WCW), .IDXW(IDXW), .CNTW(CNTW)
  ) u_plan (
    .be        (plan_be),
    .span_code (plan_span),
    .cur       (cur_idx),
    .cur_mask  (cur_mask),
    .first_idx (first_idx),
    .next_idx  (next_idx),
    .has_next  (has_next),
    .n_present (n_present)
  );

  // named events
  assign start_acc = start && !busy;
  assign zero_go   = start_acc && (n_present == '0);
  assign step      = busy && rdy;
  assign last_w    = !has_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_idx <= '0;
      be_q    <= '0;
      span_q  <= '0;
      mode_q  <= MODE_PASS;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        be_q    <= be;
        span_q  <= span_new;
        mode_q  <= mode_new;
        cur_idx <= first_idx;
        first_q <= 1'b1;
        if (zero_go) done_q <= 1'b1;
        else         busy   <= 1'b1;
      end else if (step) begin
        first_q <= 1'b0;
        if (has_next) begin
          cur_idx <= next_idx;
        end else begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // capture policy per conversion type
  always_comb begin
    cap_en    = 1'b0;
    cap_lanes = '0;
    unique case (mode_q)
      MODE_DIS: begin
        cap_en    = step && first_q;
        cap_lanes = be_q;
      end
      MODE_ASM: begin
        cap_en    = step;
        cap_lanes = be_q & cur_mask;
      end
      default: begin
        cap_en    = 1'b0;
        cap_lanes = '0;
      end
    endcase
  end

  bwa_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_acc),
    .cap_en (cap_en),
    .lanes  (cap_lanes),
    .din    (bus_din),
    .dout   (bus_dout)
  );

  // outputs
  always_comb begin
    cyc_active = busy;
    lane_en    = busy ? (be_q & cur_mask) : '0;
    unique case (mode_q)
      MODE_DIS: redrive = busy && !first_q;
      MODE_ASM: redrive = busy && last_w;
      default:  redrive = 1'b0;
    endcase
  end

  assign done = done_q;

endmodule

// File: rtl/bwa_seq_chk.sv
module bwa_seq_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rdy,
  input logic             cyc_active,
  input logic [LANES-1:0] lane_en,
  input logic             redrive,
  input logic             done,
  input logic [LANES-1:0] be_q,
  input logic [1:0]       mode_q,
  input logic             last_w,
  input logic             zero_go
);

  p_lanes_in_be_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_active |-> (lane_en != '0) && ((lane_en & ~be_q) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && !rdy) |=> (cyc_active && $stable(lane_en)));

  p_dis_later_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && rdy && !last_w && mode_q == 2'd2) |=> redrive);

  p_asm_last_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (redrive && mode_q == 2'd1) |-> last_w);

  p_pass_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> !redrive);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && rdy && last_w) || zero_go |=> done);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && start) |=> $stable(be_q));

endmodule

bind bwa_seq bwa_seq_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .rdy        (rdy),
  .cyc_active (cyc_active),
  .lane_en    (lane_en),
  .redrive    (redrive),
  .done       (done),
  .be_q       (be_q),
  .mode_q     (mode_q),
  .last_w     (last_w),
  .zero_go    (zero_go)
);

// File: tb/sim_bwa_seq.sv
`timescale 1ns/1ps
module sim_bwa_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mst_wcode = '0;
  logic [1:0]  slv_wcode = '0;
  logic [3:0]  be = '0;
  logic        rdy = 1'b0;
  logic [31:0] bus_din = '0;
  logic        cyc_active;
  logic [3:0]  lane_en;
  logic        redrive;
  logic        done;
  logic [31:0] bus_dout;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bwa_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mst_wcode(mst_wcode),
    .slv_wcode(slv_wcode), .be(be), .rdy(rdy), .bus_din(bus_din),
    .cyc_active(cyc_active), .lane_en(lane_en), .redrive(redrive),
    .done(done), .bus_dout(bus_dout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int i);
    return 32'hA1B2C3D4 + 32'h10101010 * i;
  endfunction

  function automatic logic [31:0] bytes_of(logic [3:0] m);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = m[l] ? 8'hFF : 8'h00;
    return r;
  endfunction

  // poke: raise a stray start while the first sub-cycle waits for ready
  task automatic run_xfer(input string tag, input int mc, input int sc,
                          input logic [3:0] ben, input bit poke);
    int cm, cs, nb, cnt, kind;
    logic [3:0]  chunks [4];
    logic [31:0] exp_dout;
    string rq;
    cm = (mc > 2) ? 2 : mc;
    cs = (sc > 2) ? 2 : sc;
    nb = 1 << ((cm < cs) ? cm : cs);
    cnt = 0;
    for (int k = 0; k < 4 / nb; k++) begin
      logic [3:0] m;
      m = ben & 4'(((1 << nb) - 1) << (k * nb));
      if (m != 0) begin chunks[cnt] = m; cnt++; end
    end
    // kind: 0 pass, 1 assemble, 2 disassemble
    kind = (cm == cs || cnt < 2) ? 0 : (cm > cs) ? 2 : 1;
    rq = (kind == 2) ? "R4" : (kind == 1) ? "R5" : "R6";
    exp_dout = '0;

    @(negedge clk);
    mst_wcode = 2'(mc); slv_wcode = 2'(sc); be = ben; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cnt == 0) begin
      chk(done && !cyc_active, "R7", {tag, " zero-enable done"},
          {30'd0, cyc_active, done}, 32'd1);
      @(negedge clk);
      chk(!done, "R7", {tag, " done width"}, {31'd0, done}, 32'd0);
      return;
    end
    for (int i = 0; i < cnt; i++) begin
      bit exp_rd;
      exp_rd = (kind == 2) ? (i > 0) : (kind == 1) ? (i == cnt - 1) : 1'b0;
      chk(cyc_active && lane_en == chunks[i], "R2", {tag, " lanes"},
          {27'd0, cyc_active, lane_en}, {27'd1, chunks[i]});
      chk(redrive == exp_rd, rq, {tag, " redrive tag"},
          {31'd0, redrive}, {31'd0, exp_rd});
      if (kind == 2 && i > 0)
        chk(bus_dout == (pat(0) & bytes_of(ben)), "R9", {tag, " redrive data"},
            bus_dout, pat(0) & bytes_of(ben));
      if (i == 0) begin
        if (poke) begin
          start = 1'b1; be = 4'b0001; mst_wcode = 2'd0; slv_wcode = 2'd0;
        end
        @(negedge clk);
        start = 1'b0;
        chk(cyc_active && lane_en == chunks[0], poke ? "R8" : "R3",
            {tag, " hold without ready"}, {27'd0, cyc_active, lane_en},
            {27'd1, chunks[0]});
      end
      if (kind == 2 && i == 0) exp_dout = pat(0) & bytes_of(ben);
      if (kind == 1) exp_dout = exp_dout | (pat(i) & bytes_of(chunks[i]));
      rdy = 1'b1; bus_din = pat(i);
      @(negedge clk);
      rdy = 1'b0;
    end
    chk(done && !cyc_active && lane_en == 4'd0, "R7", {tag, " done after last"},
        {27'd0, cyc_active, lane_en, done}, 32'd1);
    chk(bus_dout == exp_dout, "R9", {tag, " captured word"}, bus_dout, exp_dout);
    @(negedge clk);
    chk(!done, "R7", {tag, " done one clock"}, {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!cyc_active && !redrive && !done && lane_en == 0 && bus_dout == 0,
        "R1", "reset state", {25'd0, cyc_active, redrive, done, lane_en}, 32'd0);
  endtask

  initial begin
    #(2_000_000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_xfer("dis32to8 full", 2, 0, 4'b1111, 1'b0);
    run_xfer("dis32to16 sparse", 2, 1, 4'b0110, 1'b0);
    run_xfer("asm8to32 sparse", 0, 2, 4'b1101, 1'b0);
    run_xfer("asm16to32 full", 1, 2, 4'b1111, 1'b0);
    run_xfer("equal32", 2, 2, 4'b1011, 1'b0);
    run_xfer("one chunk", 2, 1, 4'b1100, 1'b0);
    run_xfer("equal16", 1, 1, 4'b1111, 1'b0);
    run_xfer("code3 dis", 3, 1, 4'b1111, 1'b0);
    run_xfer("zero be", 2, 0, 4'b0000, 1'b0);
    run_xfer("busy start", 2, 0, 4'b1011, 1'b1);
    run_xfer("asm8to16", 0, 1, 4'b0011, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule